// File: doc/BRIEF.md
# Digital PLL Bit Clock Recovery

This block pulls a bit clock out of a serial receive line. The block clock is an oversampling clock that runs at sixteen times the nominal bit rate. The raw line first passes through a synchroniser. The block then waits for a transition and aligns a phase counter to that transition. From there it keeps the counter aligned by watching for transitions inside a short window around each expected bit boundary. At the middle of each bit it raises a one-tick strobe and presents the synchronised line level.

Two line codings are supported. For NRZI every bit boundary window is checked. For FM only every other boundary window is checked and used for correction. A checked window that sees no transition is recorded in a sticky flag. Two checked windows in a row without a transition set a second sticky flag and drop the block back to hunting for a transition. Clearing the flags takes a disable followed by a re-enable. Decoding of the bit values and generation of the baud rate are left to neighbouring logic.

The recovered bit stream leaves through a strobe that acts as a valid with no ready. The line cannot be paused, so there is no back-pressure. The consumer must take the bit in the tick the strobe is high, or lose it.

Top module: `dpll_clk_recover`

## Requirements
- R1: While `en` is low the block is held in the hunting state: `bit_stb` stays 0 and both missing flags read 0, whatever the line does.
- R2: `rxd` passes through two flip-flops before use. A transition is a difference between the synchronised level and the level one tick earlier. `bit_dat` is the synchronised level in the tick `bit_stb` is high.
- R3: When hunting with `en` high, the first transition locks the block. The tick that sees it counts as phase 0. `bit_stb` rises 8 ticks later and then every 16 ticks, as long as no correction is made.
- R4: The boundary window spans phases 14, 15, 0, 1 and 2. A transition at phase 14 or 15 makes the counter jump one extra tick, so the next strobe comes one tick earlier. A transition at phase 1 or 2 makes the counter hold for one tick. Transitions outside the window have no effect.
- R5: `miss_one` is set when a checked window closes (at the end of phase 2) without a transition. It stays set while `en` stays high.
- R6: If two checked windows close in a row without a transition, `miss_two` is set and the block returns to hunting. No strobe occurs until a new transition locks it again.
- R7: Both flags clear only while `en` is low. A disable followed by an enable therefore clears them, and a relock with `en` held high does not.
- R8: With `enc_fm` = 1 (FM), only alternate windows are checked. The window at the locking boundary is checked, the next is not, and so on. A transition in an unchecked window neither corrects the phase nor counts. With `enc_fm` = 0 (NRZI) every window is checked.
- R9: `bit_stb` is high for exactly one tick per bit and never in two adjacent ticks.
- R10: `miss_two` is never high without `miss_one`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, 16 ticks per bit |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enable; low holds the block hunting and clears both flags |
| enc_fm | input | 1 | Line coding: 0 = NRZI, 1 = FM |
| rxd | input | 1 | Raw receive line |
| bit_stb | output | 1 | One-tick strobe at each bit centre (valid, no ready) |
| bit_dat | output | 1 | Synchronised line level, meaningful when `bit_stb` is high |
| miss_one | output | 1 | Sticky: a checked window closed without a transition |
| miss_two | output | 1 | Sticky: two checked windows in a row closed without a transition |

## Verification
The hardest situation to reach from the ports is an FM stream whose transitions fall only on the checked boundaries. In that case the block must report nothing missing, while the same waveform under NRZI must raise `miss_one`. The stimulus reaches this case by disabling and re-enabling just before a train of transitions spaced two bit periods apart. That forces the lock onto the first transition of the train, so the train's boundaries line up with the checked parity. Phase tracking is pushed with trains of transitions at 15 and 17 ticks, so every window sees an early or late correction. Missing-edge recovery is reached by letting the line go idle after lock.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_TRACK  = 1'b1
  } dpll_state_e;

  typedef struct packed {
    logic early;
    logic ontime;
    logic late;
  } win_pos_t;

endpackage

// File: rtl/dpll_sync.sv
module dpll_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dat,
  output logic chg
);

  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh[0] <= 1'b0;
    else        sh[0] <= din;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh[g] <= 1'b0;
      else        sh[g] <= sh[g-1];
    end
  end

  assign dat = sh[STAGES-1];
  assign chg = sh[STAGES-1] ^ sh[STAGES];

endmodule

// File: rtl/dpll_window.sv
module dpll_window
  import dpll_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int WIN_EARLY = 2,
  parameter int WIN_LATE  = 2,
  localparam int PW       = $clog2(OSR)
) (
  input  logic [PW-1:0] phase,
  output win_pos_t      pos
);

  localparam logic [PW-1:0] EARLY_LO = PW'(OSR - WIN_EARLY);
  localparam logic [PW-1:0] LATE_HI  = PW'(WIN_LATE);

  always_comb begin
    pos.early  = (phase >= EARLY_LO);
    pos.ontime = (phase == '0);
    pos.late   = (phase != '0) && (phase <= LATE_HI);
  end

endmodule

// File: rtl/dpll_phase.sv
module dpll_phase #(
  parameter int OSR = 16,
  localparam int PW = $clog2(OSR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          lock,
  input  logic          adv,
  input  logic          ret,
  output logic [PW-1:0] phase
);

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p, input int unsigned k);
    int unsigned s;
    s = int'(p) + k;
    return PW'(s % OSR);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (lock)    phase <= PW'(1);
    else if (!run)    phase <= '0;
    else if (adv)     phase <= step(phase, 2);
    else if (ret)     phase <= phase;
    else              phase <= step(phase, 1);
  end

  // R3: the locking tick is phase 0, so the following tick is phase 1
  a_r3_lock_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock) |-> phase == PW'(1));

  // R4: a late transition holds the counter for one tick
  a_r4_late_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && $past(ret) && !$past(lock)) |-> $stable(phase));

endmodule

// File: rtl/dpll_track.sv
module dpll_track
  import dpll_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int WIN_LATE = 2,
  localparam int PW      = $clog2(OSR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          enc_fm,
  input  logic          chg,
  input  logic [PW-1:0] phase,
  input  win_pos_t      pos,
  output dpll_state_e   state,
  output logic          lock,
  output logic          adv,
  output logic          ret,
  output logic          miss_one,
  output logic          miss_two
);

  localparam logic [PW-1:0] CLOSE_PH = PW'(WIN_LATE);

  logic seen, skip, pend;
  logic in_win, checked, act, close_w;

  assign in_win  = pos.early | pos.ontime | pos.late;
  assign checked = !(enc_fm && skip);
  assign lock    = en && (state == ST_SEARCH) && chg;
  assign act     = (state == ST_TRACK) && in_win && chg && checked;
  assign adv     = act && pos.early;
  assign ret     = act && pos.late;
  assign close_w = (state == ST_TRACK) && (phase == CLOSE_PH) && !ret;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_SEARCH; seen <= 1'b0; skip <= 1'b0; pend <= 1'b0;
      miss_one <= 1'b0; miss_two <= 1'b0;
    end else if (!en) begin
      state <= ST_SEARCH; seen <= 1'b0; skip <= 1'b0; pend <= 1'b0;
      miss_one <= 1'b0; miss_two <= 1'b0;
    end else if (lock) begin
      state <= ST_TRACK; seen <= 1'b1; skip <= 1'b0; pend <= 1'b0;
    end else if (state == ST_TRACK) begin
      if (act) seen <= 1'b1;
      if (close_w) begin
        seen <= 1'b0;
        if (enc_fm) skip <= ~skip;
        if (checked) begin
          if (seen) begin
            pend <= 1'b0;
          end else begin
            miss_one <= 1'b1;
            if (pend) begin
              miss_two <= 1'b1;
              state    <= ST_SEARCH;
              pend     <= 1'b0;
            end else begin
              pend <= 1'b1;
            end
          end
        end
      end
    end
  end

  // R6: the second flag and the drop back to hunting happen together
  a_r6_two_miss_search: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miss_two) |-> state == ST_SEARCH);

  // R5: the first flag holds while enable stays high
  a_r5_miss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(miss_one)) |-> miss_one);

  // R7: a tick with enable low leaves both flags clear
  a_r7_clear_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (!miss_one && !miss_two));

  // R10: flag ordering
  a_r10_flag_order: assert property (@(posedge clk) disable iff (!rst_n)
    miss_two |-> miss_one);

endmodule

// File: rtl/dpll_clk_recover.sv
module dpll_clk_recover
  import dpll_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SAMPLE_TICK = 8,
  parameter int WIN_EARLY   = 2,
  parameter int WIN_LATE    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic enc_fm,
  input  logic rxd,
  output logic bit_stb,
  output logic bit_dat,
  output logic miss_one,
  output logic miss_two
);

  localparam int PW = $clog2(OSR);
  localparam logic [PW-1:0] SMP_PH = PW'(SAMPLE_TICK);

  logic          dat_s, chg;
  logic [PW-1:0] phase;
  win_pos_t      pos;
  dpll_state_e   state;
  logic          lock, adv, ret;

  dpll_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dat(dat_s), .chg(chg)
  );

  dpll_window #(.OSR(OSR), .WIN_EARLY(WIN_EARLY), .WIN_LATE(WIN_LATE)) u_win (
    .phase(phase), .pos(pos)
  );

  dpll_track #(.OSR(OSR), .WIN_LATE(WIN_LATE)) u_track (
    .clk(clk), .rst_n(rst_n), .en(en), .enc_fm(enc_fm), .chg(chg),
    .phase(phase), .pos(pos), .state(state), .lock(lock), .adv(adv),
    .ret(ret), .miss_one(miss_one), .miss_two(miss_two)
  );

  dpll_phase #(.OSR(OSR)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(state == ST_TRACK), .lock(lock),
    .adv(adv), .ret(ret), .phase(phase)
  );

  assign bit_stb = (state == ST_TRACK) && (phase == SMP_PH);
  assign bit_dat = dat_s;

  // R9: a strobe never lasts two ticks
  a_r9_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);

  // R1: no strobe while disabled
  a_r1_quiet_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !bit_stb);

endmodule

// File: tb/sim_dpll_clk_recover.sv
module sim_dpll_clk_recover;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic enc_fm = 1'b0;
  logic rxd = 1'b0;
  logic bit_stb, bit_dat, miss_one, miss_two;

  int checks = 0;
  int errors = 0;
  int stb_cnt = 0;
  bit done = 1'b0;
  bit prev_stb = 1'b0;

  always #2 clk = ~clk;

  dpll_clk_recover u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .enc_fm(enc_fm), .rxd(rxd),
    .bit_stb(bit_stb), .bit_dat(bit_dat), .miss_one(miss_one), .miss_two(miss_two)
  );

  // behavioural reference, integer state, updated on each clock
  int m_s1, m_s2, m_s3, m_trk, m_ph, m_seen, m_skip, m_pend, m_m1, m_m2;

  always @(posedge clk) begin
    int edge_now, inwin, chkd, act, early, late, closing, nph, hit;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_trk = 0; m_ph = 0; m_seen = 0;
      m_skip = 0; m_pend = 0; m_m1 = 0; m_m2 = 0;
    end else begin
      edge_now = (m_s2 != m_s3);
      if (!en) begin
        m_trk = 0; m_ph = 0; m_seen = 0; m_skip = 0; m_pend = 0; m_m1 = 0; m_m2 = 0;
      end else if (m_trk == 0) begin
        if (edge_now != 0) begin
          m_trk = 1; m_ph = 1; m_seen = 1; m_skip = 0; m_pend = 0;
        end else m_ph = 0;
      end else begin
        inwin = (m_ph >= 14 || m_ph <= 2);
        chkd = !(enc_fm && m_skip != 0);
        act = inwin && edge_now != 0 && chkd;
        early = act && m_ph >= 14;
        late = act && m_ph >= 1 && m_ph <= 2;
        closing = (m_ph == 2) && !late;
        hit = m_seen;
        if (act) m_seen = 1;
        nph = early ? (m_ph + 2) % 16 : (late ? m_ph : (m_ph + 1) % 16);
        if (closing) begin
          m_seen = 0;
          if (enc_fm) m_skip = 1 - m_skip;
          if (chkd) begin
            if (hit != 0) m_pend = 0;
            else begin
              m_m1 = 1;
              if (m_pend != 0) begin m_m2 = 1; m_trk = 0; m_pend = 0; end
              else m_pend = 1;
            end
          end
        end
        m_ph = nph;
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = rxd;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int es;
      es = (m_trk != 0 && m_ph == 8);
      chk(bit_stb == es[0], "R3/R4 strobe vs model", bit_stb, es);
      if (es != 0) chk(bit_dat == m_s2[0], "R2 sampled level", bit_dat, m_s2);
      chk(miss_one == m_m1[0], "R5 miss_one vs model", miss_one, m_m1);
      chk(miss_two == m_m2[0], "R6 miss_two vs model", miss_two, m_m2);
      chk(!(miss_two && !miss_one), "R10 flag order", miss_two, 0);
      if (bit_stb) chk(!prev_stb, "R9 strobe width", prev_stb, 0);
      if (bit_stb) stb_cnt++;
      prev_stb = bit_stb;
    end
  end

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edges(input int n, input int per);
    for (int i = 0; i < n; i++) begin
      rxd = ~rxd;
      gap(per);
    end
  endtask

  task automatic fm_bits(input int n, input int per);
    for (int i = 0; i < n; i++) begin
      rxd = ~rxd;
      gap(per / 2);
      if (i % 2 == 1) rxd = ~rxd;
      gap(per - per / 2);
    end
  endtask

  task automatic recycle(input bit m);
    en = 1'b0;
    gap(3);
    enc_fm = m;
    en = 1'b1;
    gap(1);
  endtask

  initial begin
    int base;
    gap(3);
    rst_n = 1'b1;
    gap(2);
    chk(bit_stb == 1'b0 && miss_one == 1'b0 && miss_two == 1'b0, "R1 reset state", bit_stb, 0);

    // R1: line activity while disabled
    edges(6, 7);
    chk(stb_cnt == 0, "R1 no strobe when disabled", stb_cnt, 0);
    chk(miss_one == 1'b0, "R1 flag low when disabled", miss_one, 0);

    // R3: lock and steady NRZI stream
    en = 1'b1;
    base = stb_cnt;
    edges(20, 16);
    chk(stb_cnt - base >= 18, "R3 strobes after lock", stb_cnt - base, 19);
    chk(miss_one == 1'b0, "R5 no miss on steady stream", miss_one, 0);

    // R4: fast and slow lines
    edges(20, 15);
    chk(miss_one == 1'b0, "R4 early tracking", miss_one, 0);
    edges(20, 17);
    chk(miss_one == 1'b0, "R4 late tracking", miss_one, 0);

    // R5/R6: line goes quiet
    gap(60);
    chk(miss_one == 1'b1, "R5 single miss flagged", miss_one, 1);
    chk(miss_two == 1'b1, "R6 double miss flagged", miss_two, 1);
    base = stb_cnt;
    gap(40);
    chk(stb_cnt == base, "R6 hunting gives no strobe", stb_cnt - base, 0);

    // R7: relock keeps the flags
    edges(10, 16);
    chk(stb_cnt > base, "R3 relock strobes", stb_cnt - base, 9);
    chk(miss_one == 1'b1 && miss_two == 1'b1, "R7 flags sticky over relock", miss_one, 1);
    recycle(1'b0);
    chk(miss_one == 1'b0 && miss_two == 1'b0, "R7 flags cleared by recycle", miss_one, 0);

    // R8: FM with data, every boundary transitions
    recycle(1'b1);
    fm_bits(20, 16);
    chk(miss_one == 1'b0, "R8 FM steady stream", miss_one, 0);

    // R8: FM with transitions only on checked boundaries
    recycle(1'b1);
    edges(10, 32);
    chk(miss_one == 1'b0, "R8 FM alternate windows unchecked", miss_one, 0);

    // R8: same waveform under NRZI must flag a miss
    recycle(1'b0);
    edges(10, 32);
    chk(miss_one == 1'b1, "R8 NRZI checks every window", miss_one, 1);
    chk(miss_two == 1'b0, "R6 single misses do not chain", miss_two, 0);

    gap(4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R1-timeout actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule